// File: doc/BRIEF.md
# Serial Frame Length Guard

This block sits beside the command decoder of a three-wire serial memory slave. It counts how many serial-clock rising edges arrive from the edge that carries the start bit until the chip select input goes low. At that moment it compares the count with the exact frame length that the decoded command needs in the current organisation. Only an exact match lets the programming cycle start. A glitch on the serial clock adds a pulse, and a host that ends a frame early removes some. Either case shifts the address and data bits, so the frame must not program anything.

All inputs are already synchronous to the system clock. `sclk_rise` is a one-cycle strobe for each serial-clock rising edge. `start_seen` is raised together with the strobe of the edge that carries the start bit. The decoder supplies the command class and the organisation bit. The block returns two one-cycle pulses. `commit_ok` allows the programming cycle. `len_err` marks a gated command that was cancelled because its length was wrong. Decoding the command and doing the programming are left to neighbouring blocks.

Top module: `frame_len_guard`

## Requirements
- R1: Counting is armed by the strobe that comes with `start_seen`, and that strobe counts as pulse 1. Strobes received while armed add one each. Strobes before the start bit are not counted.
- R2: Command code 1 (single write) needs 3 + A + D pulses. A is ADDR_W in byte mode (`org_word`=0) and ADDR_W-1 in word mode. D is BYTE_W or WORD_W. With the default values this is 20 in byte mode and 27 in word mode.
- R3: Command codes 2 (single erase) and 3 (erase all) need 3 + A pulses: 12 in byte mode and 11 in word mode with the default values.
- R4: Command code 4 (write all) needs the same length as the single write in the same organisation.
- R5: When a gated frame is exactly the required length, `commit_ok` is high for one cycle. That cycle is the one after the first cycle in which `cs` is sampled low.
- R6: When a gated frame is shorter or longer than required, `len_err` pulses in the cycle given in R5 instead, and `commit_ok` stays low.
- R7: Command codes 0 (read), 5 (write enable), 6 (write disable) and 7 (none) never raise `commit_ok` or `len_err`, whatever the count.
- R8: The pulse count holds at its ceiling instead of wrapping. A frame that is longer than required by any multiple of a power of two is still rejected.
- R9: The count clears whenever `cs` is low. A strobe in the same cycle that `cs` is first low is not counted, so a frame whose extra edge comes after chip select has fallen still commits.
- R10: While `rst` is high, and in the first cycle after it, both outputs are low.
- R11: A chip-select fall with no start bit seen in the frame raises neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_rise | input | 1 | One-cycle strobe per serial-clock rising edge |
| cs | input | 1 | Synchronised chip select, high while selected |
| start_seen | input | 1 | High with the strobe that carries the start bit |
| cmd | input | 3 | Decoded command class (codes as listed in R2, R3, R4 and R7) |
| org_word | input | 1 | 1 = word organisation, 0 = byte organisation |
| commit_ok | output | 1 | One-cycle pulse that allows programming |
| len_err | output | 1 | One-cycle pulse when a gated frame has the wrong length |

## Verification
Each verdict is due exactly one clock after the first cycle in which `cs` is sampled low, because only one register stands between the fall detection and the outputs. The count is due one clock after each strobe. Inputs are driven on the falling clock edge. A behavioural model with an unbounded integer count updates on each rising edge, and its expected pulses are compared with the outputs on every falling edge. This comparison catches a verdict that is a cycle early or late, not only a wrong verdict. Each frame is also checked afterwards by counting the pulses seen on each output.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [2:0] {
    CMD_READ   = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_ERASE  = 3'd2,
    CMD_ERALL  = 3'd3,
    CMD_WRALL  = 3'd4,
    CMD_WREN   = 3'd5,
    CMD_WRDIS  = 3'd6,
    CMD_NONE   = 3'd7
  } cmd_e;

  // Commands that modify the array and therefore need an exact length.
  function automatic logic is_guarded(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) ||
           (c == CMD_ERALL) || (c == CMD_WRALL);
  endfunction

  // Commands that carry a data field after the address.
  function automatic logic has_data(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRALL);
  endfunction

endpackage

// File: rtl/fg_pulse_counter.sv
module fg_pulse_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             sclk_rise,
  input  logic             start_seen,
  output logic [CNT_W-1:0] count,
  output logic             armed
);

  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !cs) begin
      count <= '0;
      armed <= 1'b0;
    end else if (sclk_rise) begin
      if (!armed) begin
        if (start_seen) begin
          count <= CNT_W'(1);
          armed <= 1'b1;
        end
      end else if (count != CEIL) begin
        count <= count + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/fg_len_table.sv
module fg_len_table
  import fg_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  cmd_e             cmd,
  input  logic             org_word,
  output logic [CNT_W-1:0] need_len,
  output logic             guarded
);

  localparam int HDR_W = 3;  // start bit plus two opcode bits
  localparam int LEN_NODATA_B = HDR_W + ADDR_W;
  localparam int LEN_NODATA_W = HDR_W + ADDR_W - 1;
  localparam int LEN_DATA_B   = LEN_NODATA_B + BYTE_W;
  localparam int LEN_DATA_W   = LEN_NODATA_W + WORD_W;

  logic [CNT_W-1:0] len_tab [4];

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_len
      // index bit0 = organisation, bit1 = data field present
      localparam int L = (gi == 0) ? LEN_NODATA_B :
                         (gi == 1) ? LEN_NODATA_W :
                         (gi == 2) ? LEN_DATA_B   : LEN_DATA_W;
      assign len_tab[gi] = CNT_W'(L);
    end
  endgenerate

  always_comb begin
    need_len = len_tab[{has_data(cmd), org_word}];
    guarded  = is_guarded(cmd);
  end

endmodule

// File: rtl/fg_verdict.sv
module fg_verdict #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             armed,
  input  logic             guarded,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] need_len,
  output logic             commit_ok,
  output logic             len_err
);

  logic cs_q;
  logic fall;
  logic judge;

  assign fall  = cs_q && !cs;
  assign judge = fall && armed && guarded;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b0;
      commit_ok <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      cs_q      <= cs;
      commit_ok <= judge && (count == need_len);
      len_err   <= judge && (count != need_len);
    end
  end

endmodule

// File: rtl/frame_len_guard.sv
module frame_len_guard #(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_rise,
  input  logic       cs,
  input  logic       start_seen,
  input  logic [2:0] cmd,
  input  logic       org_word,
  output logic       commit_ok,
  output logic       len_err
);

  localparam int MAX_LEN = 3 + ADDR_W + ((BYTE_W > WORD_W) ? BYTE_W : WORD_W);
  localparam int CNT_W   = $clog2(MAX_LEN + 2);

  logic [CNT_W-1:0] pulse_cnt;
  logic [CNT_W-1:0] need_len;
  logic             armed;
  logic             guarded;

  fg_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cs         (cs),
    .sclk_rise  (sclk_rise),
    .start_seen (start_seen),
    .count      (pulse_cnt),
    .armed      (armed)
  );

  fg_len_table #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_len (
    .cmd      (fg_pkg::cmd_e'(cmd)),
    .org_word (org_word),
    .need_len (need_len),
    .guarded  (guarded)
  );

  fg_verdict #(.CNT_W(CNT_W)) u_vrd (
    .clk       (clk),
    .rst       (rst),
    .cs        (cs),
    .armed     (armed),
    .guarded   (guarded),
    .count     (pulse_cnt),
    .need_len  (need_len),
    .commit_ok (commit_ok),
    .len_err   (len_err)
  );

endmodule

// File: rtl/frame_len_guard_chk.sv
module frame_len_guard_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic [2:0]       cmd,
  input logic [CNT_W-1:0] count,
  input logic             commit_ok,
  input logic             len_err
);

  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(commit_ok && len_err));

  p_after_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (commit_ok || len_err) |-> (!$past(cs) && $past(cs, 2)));

  p_single_r5: assert property (@(posedge clk) disable iff (rst)
    commit_ok |=> !commit_ok);

  p_gated_only_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_ok || len_err) |-> ($past(cmd) >= 3'd1 && $past(cmd) <= 3'd4));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(cs) |-> (count == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(cs) && !$past(rst)) |-> (count >= $past(count)));

endmodule

bind frame_len_guard frame_len_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs        (cs),
  .cmd       (cmd),
  .count     (pulse_cnt),
  .commit_ok (commit_ok),
  .len_err   (len_err)
);

// File: tb/frame_len_guard_bench.sv
`timescale 1ns/1ps
module frame_len_guard_bench;

  localparam int CLK_NS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_rise = 1'b0;
  logic       cs = 1'b0;
  logic       start_seen = 1'b0;
  logic [2:0] cmd = 3'd7;
  logic       org_word = 1'b0;
  logic       commit_ok;
  logic       len_err;

  int    n_chk = 0;
  int    n_bad = 0;
  int    saw_commit = 0;
  int    saw_err = 0;
  string cur_tag = "R10";

  // behavioural reference state
  int m_cnt = 0;
  bit m_armed = 0;
  bit m_cs_prev = 0;
  bit exp_commit = 0;
  bit exp_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  frame_len_guard u_frame_len_guard (
    .clk        (clk),
    .rst        (rst),
    .sclk_rise  (sclk_rise),
    .cs         (cs),
    .start_seen (start_seen),
    .cmd        (cmd),
    .org_word   (org_word),
    .commit_ok  (commit_ok),
    .len_err    (len_err)
  );

  function automatic bit gated(int c);
    return c >= 1 && c <= 4;
  endfunction

  function automatic int need(int c, bit org);
    int n = 3 + (org ? 8 : 9);
    if (c == 1 || c == 4) n += org ? 16 : 8;
    return n;
  endfunction

  task automatic check(bit cond, string tag, int act, int expv, string what);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // reference model: verdict from the cycle where cs is first seen low
  always @(posedge clk) begin
    bit fall;
    if (rst) begin
      m_cnt = 0; m_armed = 0; m_cs_prev = 0; exp_commit = 0; exp_err = 0;
    end else begin
      fall = m_cs_prev && !cs;
      exp_commit = fall && m_armed && gated(cmd) && (m_cnt == need(cmd, org_word));
      exp_err    = fall && m_armed && gated(cmd) && (m_cnt != need(cmd, org_word));
      if (!cs) begin
        m_cnt = 0; m_armed = 0;
      end else if (sclk_rise && !m_armed && start_seen) begin
        m_cnt = 1; m_armed = 1;
      end else if (sclk_rise && m_armed) begin
        m_cnt++;
      end
      m_cs_prev = cs;
    end
  end

  always @(negedge clk) begin
    check(commit_ok === exp_commit, cur_tag, commit_ok, exp_commit, "commit_ok per clock");
    check(len_err === exp_err, cur_tag, len_err, exp_err, "len_err per clock");
    if (commit_ok) saw_commit++;
    if (len_err) saw_err++;
  end

  task automatic frame(input int c, input bit org, input int npulse, input int pre,
                       input bit strobe_at_fall, input bit do_start,
                       input int e_commit, input int e_err, input string tag);
    cur_tag = tag;
    @(negedge clk);
    saw_commit = 0; saw_err = 0;
    cmd = 3'(c); org_word = org; cs = 1'b1;
    @(negedge clk);
    for (int i = 0; i < pre; i++) begin
      sclk_rise = 1'b1; @(negedge clk); sclk_rise = 1'b0; @(negedge clk);
    end
    for (int i = 0; i < npulse; i++) begin
      sclk_rise = 1'b1; start_seen = (i == 0) && do_start;
      @(negedge clk);
      sclk_rise = 1'b0; start_seen = 1'b0;
      @(negedge clk);
    end
    cs = 1'b0; sclk_rise = strobe_at_fall;
    @(negedge clk);
    sclk_rise = 1'b0;
    repeat (3) @(negedge clk);
    check(saw_commit == e_commit, tag, saw_commit, e_commit, "commit pulses in frame");
    check(saw_err == e_err, tag, saw_err, e_err, "error pulses in frame");
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(commit_ok === 1'b0 && len_err === 1'b0, "R10", {commit_ok, len_err}, 0, "outputs in reset");
    rst = 1'b0;
    @(negedge clk);
    check(commit_ok === 1'b0 && len_err === 1'b0, "R10", {commit_ok, len_err}, 0, "outputs after reset");

    frame(1, 0, 20, 0, 0, 1, 1, 0, "R2 byte write 20");
    frame(1, 1, 27, 0, 0, 1, 1, 0, "R2 word write 27");
    frame(1, 0, 19, 0, 0, 1, 0, 1, "R6 short write 19");
    frame(1, 0, 21, 0, 0, 1, 0, 1, "R6 long write 21");
    frame(1, 1, 26, 0, 0, 1, 0, 1, "R6 short word write 26");
    frame(2, 0, 12, 0, 0, 1, 1, 0, "R3 byte erase 12");
    frame(2, 1, 11, 0, 0, 1, 1, 0, "R3 word erase 11");
    frame(3, 0, 12, 0, 0, 1, 1, 0, "R3 erase all 12");
    frame(2, 1, 12, 0, 0, 1, 0, 1, "R6 word erase 12");
    frame(4, 0, 20, 0, 0, 1, 1, 0, "R4 byte write all 20");
    frame(4, 1, 27, 0, 0, 1, 1, 0, "R4 word write all 27");
    frame(4, 1, 11, 0, 0, 1, 0, 1, "R4 write all short");
    frame(0, 0, 20, 0, 0, 1, 0, 0, "R7 read ignored");
    frame(5, 0, 12, 0, 0, 1, 0, 0, "R7 enable ignored");
    frame(6, 1, 5, 0, 0, 1, 0, 0, "R7 disable ignored");
    frame(1, 0, 52, 0, 0, 1, 0, 1, "R8 write 52 no alias");
    frame(1, 0, 84, 0, 0, 1, 0, 1, "R8 write 84 no alias");
    frame(2, 0, 44, 0, 0, 1, 0, 1, "R8 erase 44 no alias");
    frame(1, 0, 20, 3, 0, 1, 1, 0, "R1 pre-start strobes ignored");
    frame(1, 0, 20, 0, 1, 1, 1, 0, "R9 strobe at fall ignored");
    frame(1, 0, 20, 0, 0, 0, 0, 0, "R11 no start bit");
    frame(1, 1, 27, 0, 0, 1, 1, 0, "R9 clear between frames");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule